// File: doc/BRIEF.md
# Coprocessor Host Register Interface

This block is the byte-wide register file that a host processor sees for a graphics coprocessor. It decodes a 768-byte window starting at a base address (0x3000 by default). The lower 256 bytes hold control and status registers. The upper 512 bytes hold instruction-cache storage. Several register writes and reads have side effects: they start the coprocessor, flush the cache bookkeeping, raise or drop the host interrupt, or select a RAM bank.

The execution core is not part of the block. A single `core_done` input stands in for it. That input marks the end of a run: it clears the run flag and sets the interrupt flag. The block reports which 16-byte cache lines the host has finished loading through a 32-bit line-valid vector. It also reports whether the current register settings allow the core to run.

Top module: `coproc_hostif`

## Requirements
- R1: After synchronous reset every register byte reads 0, `line_valid` is 0, and `irq`, `start_pulse`, `flush_pulse`, `run_ok` and `ram_bank` are 0.
- R2: A write to offset 0x30 (status low) that moves the run flag (bit 5) from 0 to 1 gives a one-cycle `start_pulse` in the cycle after the write. A write that leaves bit 5 unchanged gives no pulse.
- R3: A write to offset 0x30 that moves bit 5 from 1 to 0 gives a one-cycle `flush_pulse`. It clears every `line_valid` bit and clears the cache-base bytes at offsets 0x3E and 0x3F.
- R4: A write to offset 0x1F stores the byte, forces status bit 5 to 1 and gives a `start_pulse`, even when bit 5 was already 1.
- R5: Writes to offsets 0x34 and 0x36 keep only bits 6..0; bit 7 reads back 0.
- R6: Writes to offset 0x3B (version) have no effect; it always reads 0.
- R7: A read of offset 0x31 (status high) returns the value held before the read. It then clears bit 7 (the interrupt flag) and drops `irq`, unless `core_done` is high in the same cycle.
- R8: `irq` is high exactly when the interrupt flag (offset 0x31 bit 7) is 1 and the run flag is 0. A `core_done` cycle clears the run flag and sets the interrupt flag. It does not touch `line_valid`.
- R9: Host writes in the cache window are stored and read back. A write whose address has low nibble 0xF sets `line_valid[addr[8:4]]`, so 0x310F sets bit 16 and 0x32FF sets bit 15.
- R10: `run_ok` is high exactly when the run flag is 1 and bits 3 and 4 of the screen-mode register (offset 0x3A) are both 1.
- R11: `ram_bank` follows bits 1..0 of the last write to offset 0x3C. The full byte still reads back.
- R12: `rdata` holds the addressed byte in the cycle after `rd_en`. It reads 0 for addresses outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Host byte address |
| wdata | input | 8 | Host write data |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| core_done | input | 1 | End-of-run event from the execution core |
| rdata | output | 8 | Read data, valid one cycle after `rd_en` |
| start_pulse | output | 1 | One-cycle run request |
| flush_pulse | output | 1 | One-cycle cache flush indication |
| irq | output | 1 | Interrupt line to the host |
| run_ok | output | 1 | Run flag set and screen-mode enables present |
| ram_bank | output | 2 | Active RAM bank |
| line_valid | output | 32 | One flag per fully loaded cache line |

## Verification
The hardest state to reach is a stopped coprocessor with a pending interrupt while cache lines are still marked valid. The interrupt must be visible on `irq` and must survive until the status-high read. The stimulus reaches this state in order:
- load lines through the cache window;
- start the core through the status register;
- end the run with `core_done`, which must leave the lines valid;
- read offset 0x31 twice, to see the flag returned once and then cleared.

A second run starts through offset 0x1F with a host-set interrupt flag pending, so the gating of `irq` by the run flag is seen in both directions. Clearing the run flag then shows the flush clearing the lines and cache-base bytes.

// File: rtl/coproc_hostif_pkg.sv
package coproc_hostif_pkg;
  // Register offsets inside the control area; decoded by the host side
  localparam logic [7:0] OFS_KICK   = 8'h1F;
  localparam logic [7:0] OFS_ST_LO  = 8'h30;
  localparam logic [7:0] OFS_ST_HI  = 8'h31;
  localparam logic [7:0] OFS_MASK_A = 8'h34;
  localparam logic [7:0] OFS_MASK_B = 8'h36;
  localparam logic [7:0] OFS_SCMR   = 8'h3A;
  localparam logic [7:0] OFS_VER    = 8'h3B;
  localparam logic [7:0] OFS_BANK   = 8'h3C;
  localparam logic [7:0] OFS_CB_LO  = 8'h3E;
  localparam logic [7:0] OFS_CB_HI  = 8'h3F;
  // Bit positions
  localparam int GO_BIT   = 5;
  localparam int IRQ_BIT  = 7;
  localparam int MODE_B0  = 3;
  localparam int MODE_B1  = 4;

  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_REG = 2'd1, SRC_CACHE = 2'd2} rd_src_t;
endpackage

// File: rtl/coproc_hostif_regs.sv
module coproc_hostif_regs
  import coproc_hostif_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_BYTES = 256,
  localparam int RIDX_W   = $clog2(REG_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [RIDX_W-1:0] off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              core_done,
  output logic [DATA_W-1:0] rd_q,
  output logic              flush_now,
  output logic              start_pulse,
  output logic              flush_pulse,
  output logic              irq,
  output logic              run_ok,
  output logic [1:0]        ram_bank,
  output logic              go_state,
  output logic              irq_flag
);
  logic [DATA_W-1:0] mem [REG_BYTES];
  logic              nxt_go, nxt_flag, start_now;
  logic [DATA_W-1:0] nxt_mode;

  localparam logic [RIDX_W-1:0] A_KICK = RIDX_W'(OFS_KICK);
  localparam logic [RIDX_W-1:0] A_STLO = RIDX_W'(OFS_ST_LO);
  localparam logic [RIDX_W-1:0] A_STHI = RIDX_W'(OFS_ST_HI);
  localparam logic [RIDX_W-1:0] A_MSKA = RIDX_W'(OFS_MASK_A);
  localparam logic [RIDX_W-1:0] A_MSKB = RIDX_W'(OFS_MASK_B);
  localparam logic [RIDX_W-1:0] A_MODE = RIDX_W'(OFS_SCMR);
  localparam logic [RIDX_W-1:0] A_VER  = RIDX_W'(OFS_VER);
  localparam logic [RIDX_W-1:0] A_BANK = RIDX_W'(OFS_BANK);
  localparam logic [RIDX_W-1:0] A_CBLO = RIDX_W'(OFS_CB_LO);
  localparam logic [RIDX_W-1:0] A_CBHI = RIDX_W'(OFS_CB_HI);

  assign go_state = mem[A_STLO][GO_BIT];
  assign irq_flag = mem[A_STHI][IRQ_BIT];

  // Next value of the flag bits: core event first, then read clear, then host write
  always_comb begin
    nxt_go   = go_state;
    nxt_flag = irq_flag;
    if (core_done) begin
      nxt_go   = 1'b0;
      nxt_flag = 1'b1;
    end else if (rd_en && off == A_STHI) begin
      nxt_flag = 1'b0;
    end
    if (wr_en && off == A_STLO) nxt_go = wdata[GO_BIT];
    if (wr_en && off == A_KICK) nxt_go = 1'b1;
    if (wr_en && off == A_STHI) nxt_flag = wdata[IRQ_BIT];
    nxt_mode = (wr_en && off == A_MODE) ? wdata : mem[A_MODE];
  end

  assign flush_now = wr_en && off == A_STLO && go_state && !wdata[GO_BIT];
  assign start_now = (wr_en && off == A_STLO && !go_state && wdata[GO_BIT]) ||
                     (wr_en && off == A_KICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_BYTES; i++) mem[i] <= '0;
      rd_q        <= '0;
      start_pulse <= 1'b0;
      flush_pulse <= 1'b0;
      irq         <= 1'b0;
      run_ok      <= 1'b0;
      ram_bank    <= '0;
    end else begin
      if (rd_en) rd_q <= mem[off];
      if (wr_en) begin
        case (off)
          A_VER:          ;
          A_MSKA, A_MSKB: mem[off] <= {1'b0, wdata[DATA_W-2:0]};
          default:        mem[off] <= wdata;
        endcase
        if (off == A_BANK) ram_bank <= wdata[1:0];
      end
      if (flush_now) begin
        mem[A_CBLO] <= '0;
        mem[A_CBHI] <= '0;
      end
      mem[A_STLO][GO_BIT]  <= nxt_go;
      mem[A_STHI][IRQ_BIT] <= nxt_flag;
      start_pulse <= start_now;
      flush_pulse <= flush_now;
      irq         <= nxt_flag && !nxt_go;
      run_ok      <= nxt_go && nxt_mode[MODE_B0] && nxt_mode[MODE_B1];
    end
  end
endmodule

// File: rtl/coproc_hostif_cache.sv
module coproc_hostif_cache #(
  parameter int DATA_W      = 8,
  parameter int CACHE_BYTES = 512,
  parameter int LINE_BYTES  = 16,
  localparam int LINES      = CACHE_BYTES / LINE_BYTES,
  localparam int CIDX_W     = $clog2(CACHE_BYTES),
  localparam int LINE_W     = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [CIDX_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flush,
  output logic [DATA_W-1:0] rd_q,
  output logic [LINES-1:0]  line_valid
);
  logic [DATA_W-1:0] ram [CACHE_BYTES];

  // Plain single-port storage, no reset, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) ram[idx] <= wdata;
    if (rd_en) rd_q <= ram[idx];
  end

  // A line counts as loaded once its last byte is written
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      line_valid <= '0;
    end else if (wr_en && idx[LINE_W-1:0] == {LINE_W{1'b1}}) begin
      line_valid[idx[CIDX_W-1:LINE_W]] <= 1'b1;
    end
  end
endmodule

// File: rtl/coproc_hostif.sv
module coproc_hostif
  import coproc_hostif_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter logic [15:0] BASE_ADDR   = 16'h3000,
  parameter int          REG_BYTES   = 256,
  parameter int          CACHE_BYTES = 512,
  parameter int          LINE_BYTES  = 16,
  localparam int         LINES       = CACHE_BYTES / LINE_BYTES,
  localparam int         TOTAL       = REG_BYTES + CACHE_BYTES,
  localparam int         RIDX_W      = $clog2(REG_BYTES),
  localparam int         CIDX_W      = $clog2(CACHE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              core_done,
  output logic [DATA_W-1:0] rdata,
  output logic              start_pulse,
  output logic              flush_pulse,
  output logic              irq,
  output logic              run_ok,
  output logic [1:0]        ram_bank,
  output logic [LINES-1:0]  line_valid
);
  logic [ADDR_W-1:0] off;
  logic              in_win, reg_sel, cache_sel, flush_now;
  logic              go_state, irq_flag;
  logic [DATA_W-1:0] reg_rd, cache_rd;
  rd_src_t           src_q;

  assign off       = addr - ADDR_W'(BASE_ADDR);
  assign in_win    = (addr >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(TOTAL));
  assign reg_sel   = in_win && (off < ADDR_W'(REG_BYTES));
  assign cache_sel = in_win && !reg_sel;

  coproc_hostif_regs #(.DATA_W(DATA_W), .REG_BYTES(REG_BYTES)) u_regs (
    .clk, .rst,
    .wr_en      (wr_en && reg_sel),
    .rd_en      (rd_en && reg_sel),
    .off        (off[RIDX_W-1:0]),
    .wdata,
    .core_done,
    .rd_q       (reg_rd),
    .flush_now,
    .start_pulse, .flush_pulse, .irq, .run_ok, .ram_bank,
    .go_state, .irq_flag
  );

  coproc_hostif_cache #(.DATA_W(DATA_W), .CACHE_BYTES(CACHE_BYTES), .LINE_BYTES(LINE_BYTES)) u_cache (
    .clk, .rst,
    .wr_en      (wr_en && cache_sel),
    .rd_en      (rd_en && cache_sel),
    .idx        (off[CIDX_W-1:0]),
    .wdata,
    .flush      (flush_now),
    .rd_q       (cache_rd),
    .line_valid
  );

  always_ff @(posedge clk) begin
    if (rst)         src_q <= SRC_NONE;
    else if (rd_en)  src_q <= reg_sel ? SRC_REG : (cache_sel ? SRC_CACHE : SRC_NONE);
  end

  always_comb begin
    case (src_q)
      SRC_REG:   rdata = reg_rd;
      SRC_CACHE: rdata = cache_rd;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/coproc_hostif_checker.sv
module coproc_hostif_checker #(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] BASE_ADDR   = 16'h3000,
  parameter int          REG_BYTES   = 256,
  parameter int          CACHE_BYTES = 512,
  parameter int          LINE_BYTES  = 16,
  localparam int         LINES       = CACHE_BYTES / LINE_BYTES,
  localparam int         LINE_W      = $clog2(LINE_BYTES),
  localparam int         LSEL_W      = $clog2(LINES)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic              core_done,
  input logic              start_pulse,
  input logic              flush_pulse,
  input logic              irq,
  input logic              run_ok,
  input logic [LINES-1:0]  line_valid,
  input logic              go_state,
  input logic              irq_flag
);
  localparam logic [ADDR_W-1:0] STHI_A = ADDR_W'(BASE_ADDR) + ADDR_W'(8'h31);
  localparam logic [ADDR_W-1:0] C_LO   = ADDR_W'(BASE_ADDR) + ADDR_W'(REG_BYTES);
  localparam logic [ADDR_W-1:0] C_HI   = ADDR_W'(BASE_ADDR) + ADDR_W'(REG_BYTES + CACHE_BYTES);

  logic cache_hit;
  assign cache_hit = wr_en && addr >= C_LO && addr < C_HI && addr[LINE_W-1:0] == {LINE_W{1'b1}};

  p_pulses_apart_r2: assert property (@(posedge clk) disable iff (rst)
    !(start_pulse && flush_pulse));

  p_flush_empties_r3: assert property (@(posedge clk) disable iff (rst)
    flush_pulse |-> line_valid == '0);

  p_start_sets_go_r4: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> go_state);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == STHI_A && !wr_en && !core_done) |=> !irq_flag && !irq);

  p_irq_rule_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_flag && !go_state));

  p_line_mark_r9: assert property (@(posedge clk) disable iff (rst)
    cache_hit |=> line_valid[$past(addr[LSEL_W+LINE_W-1:LINE_W])]);

  p_run_needs_go_r10: assert property (@(posedge clk) disable iff (rst)
    run_ok |-> go_state);
endmodule

bind coproc_hostif coproc_hostif_checker #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .REG_BYTES(REG_BYTES),
  .CACHE_BYTES(CACHE_BYTES), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .core_done(core_done), .start_pulse(start_pulse), .flush_pulse(flush_pulse),
  .irq(irq), .run_ok(run_ok), .line_valid(line_valid),
  .go_state(go_state), .irq_flag(irq_flag)
);

// File: tb/coproc_hostif_test.sv
module coproc_hostif_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, core_done = 1'b0;
  logic [7:0]  rdata;
  logic        start_pulse, flush_pulse, irq, run_ok;
  logic [1:0]  ram_bank;
  logic [31:0] line_valid;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t exp_q[$];
  logic  rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coproc_hostif uut (
    .clk, .rst, .addr, .wdata, .wr_en, .rd_en, .core_done,
    .rdata, .start_pulse, .flush_pulse, .irq, .run_ok, .ram_bank, .line_valid
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read result one cycle after its strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      chk(rdata === it.exp, it.tag, {24'd0, rdata}, {24'd0, it.exp});
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(start_pulse == 0 && flush_pulse == 0, "R1 pulses", {30'd0, start_pulse, flush_pulse}, 0);
    chk(irq == 0 && run_ok == 0, "R1 irq/run", {30'd0, irq, run_ok}, 0);
    chk(line_valid == 0, "R1 valid", line_valid, 0);
    chk(ram_bank == 0, "R1 bank", {30'd0, ram_bank}, 0);
    rd(16'h3030, 8'h00, "R1 status lo");
    rd(16'h3031, 8'h00, "R1 status hi");
    rd(16'h303E, 8'h00, "R1 cache base");

    // R12 plain storage and outside window
    wr(16'h3000, 8'hA5);
    rd(16'h3000, 8'hA5, "R12 readback");
    rd(16'h2FFF, 8'h00, "R12 below window");
    rd(16'h3300, 8'h00, "R12 above window");

    // R5 masked registers
    wr(16'h3034, 8'hFF);
    rd(16'h3034, 8'h7F, "R5 mask 34");
    wr(16'h3036, 8'h80);
    rd(16'h3036, 8'h00, "R5 mask 36");

    // R6 version ignored
    wr(16'h303B, 8'h5A);
    rd(16'h303B, 8'h00, "R6 version");

    // R11 bank select
    wr(16'h303C, 8'hFE);
    chk(ram_bank == 2'd2, "R11 bank", {30'd0, ram_bank}, 2);
    rd(16'h303C, 8'hFE, "R11 readback");

    // R9 cache lines
    for (int i = 0; i < 15; i++) wr(16'h3100 + 16'(i), 8'h40 + 8'(i));
    chk(line_valid == 0, "R9 partial line", line_valid, 0);
    wr(16'h310F, 8'h4F);
    chk(line_valid == 32'h0001_0000, "R9 line 16", line_valid, 32'h0001_0000);
    wr(16'h32FF, 8'hC3);
    chk(line_valid == 32'h0001_8000, "R9 line 15", line_valid, 32'h0001_8000);
    rd(16'h3105, 8'h45, "R9 cache read");
    rd(16'h32FF, 8'hC3, "R9 cache read top");

    // R10 mode bits without run flag
    wr(16'h303A, 8'h18);
    chk(run_ok == 0, "R10 no go", {31'd0, run_ok}, 0);

    // R2 start on rising run flag
    wr(16'h3030, 8'h20);
    chk(start_pulse == 1 && flush_pulse == 0, "R2 start", {30'd0, start_pulse, flush_pulse}, 2);
    chk(run_ok == 1, "R10 run ok", {31'd0, run_ok}, 1);
    idle();
    chk(start_pulse == 0, "R2 single cycle", {31'd0, start_pulse}, 0);
    wr(16'h3030, 8'h20);
    chk(start_pulse == 0, "R2 no change", {31'd0, start_pulse}, 0);

    // R8 core completion
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
    chk(irq == 1, "R8 irq raised", {31'd0, irq}, 1);
    chk(run_ok == 0, "R8 run dropped", {31'd0, run_ok}, 0);
    chk(line_valid == 32'h0001_8000, "R8 lines kept", line_valid, 32'h0001_8000);
    rd(16'h3030, 8'h00, "R8 go cleared");

    // R7 status high read clears
    rd(16'h3031, 8'h80, "R7 flag returned");
    chk(irq == 0, "R7 irq dropped", {31'd0, irq}, 0);
    rd(16'h3031, 8'h00, "R7 flag cleared");

    // R8 gating by run flag, R4 kick register
    wr(16'h3031, 8'h80);
    chk(irq == 1, "R8 host flag", {31'd0, irq}, 1);
    wr(16'h301F, 8'h77);
    chk(start_pulse == 1, "R4 start", {31'd0, start_pulse}, 1);
    chk(irq == 0, "R8 gated by go", {31'd0, irq}, 0);
    rd(16'h301F, 8'h77, "R4 stored");
    rd(16'h3030, 8'h20, "R4 go forced");
    wr(16'h301F, 8'h01);
    chk(start_pulse == 1, "R4 repeat start", {31'd0, start_pulse}, 1);

    // R3 flush on falling run flag
    wr(16'h303E, 8'h12);
    wr(16'h303F, 8'h34);
    wr(16'h3030, 8'h00);
    chk(flush_pulse == 1 && start_pulse == 0, "R3 flush", {30'd0, start_pulse, flush_pulse}, 1);
    chk(line_valid == 0, "R3 lines cleared", line_valid, 0);
    chk(irq == 1, "R8 irq after stop", {31'd0, irq}, 1);
    rd(16'h303E, 8'h00, "R3 base lo");
    rd(16'h303F, 8'h00, "R3 base hi");
    idle();
    chk(flush_pulse == 0, "R3 single cycle", {31'd0, flush_pulse}, 0);

    // R10 one mode bit missing
    wr(16'h303A, 8'h08);
    wr(16'h3030, 8'h20);
    chk(run_ok == 0, "R10 bit4 missing", {31'd0, run_ok}, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all reads seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule